// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses for one SDRAM read or write burst. The controller pulses `start` along with a starting column and a read/write flag. From the next clock on, the block emits one column address per cycle, with `col_valid` high on each beat and `col_last` marking the final beat. The burst settings are latched with the start pulse: the length (1, 2, 4, 8 or a whole page), the beat ordering (sequential or interleaved) and a write-single option.

In the fixed-length modes the beats wrap inside the aligned block that holds the starting column. In full-page mode the whole column field counts upward and wraps at the page edge. It keeps going until a stop arrives. A stop input ends the burst at the current beat; it covers both a burst-stop and a precharge. When the write-single option is on, every write is one beat long and reads keep the programmed length.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: While `rst` is high, and after it until the first start is sampled, `col_valid` and `col_last` are 0.
- R2: In the cycle after a rising edge that samples `start`=1, `col_valid` is 1 and `col_addr` equals the sampled `start_col`. The following beats come one per clock.
- R3: The `mode_blen` code sets the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives a full page. The reserved codes 4, 5 and 6 give 1 beat. A burst that is not cut short keeps `col_valid` high for exactly that many cycles.
- R4: With sequential ordering (`mode_ilv`=0) and a length of N beats, beat i has its low log2(N) bits equal to (start + i) mod N. The bits above them are copied from the starting column.
- R5: With interleaved ordering (`mode_ilv`=1) and a length of N beats, beat i has its low log2(N) bits equal to the start's low bits XOR i. The bits above them are copied from the starting column.
- R6: In full-page mode, beat i is (start + i) mod 2^COL_W. The burst never ends by itself. `mode_ilv` is ignored in this mode.
- R7: `col_last` is 1 on the final beat of a burst. Unless a new start is sampled in that same cycle, `col_valid` is 0 in the next cycle.
- R8: When `stop` is 1 during a valid beat, that beat carries `col_last`=1 and no further beats follow. A stop while no burst is active has no effect.
- R9: When `mode_wr_single`=1 and `start_is_wr`=1, the burst is exactly one beat. Reads with `mode_wr_single`=1 keep the programmed length, and so do writes with `mode_wr_single`=0.
- R10: Changes on the mode inputs during a burst do not affect that burst. The settings are taken only with `start`.
- R11: A start sampled during a burst abandons the old burst. The new burst's first beat appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_blen | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 = interleaved ordering, 0 = sequential |
| mode_wr_single | input | 1 | 1 = writes are single-beat |
| start | input | 1 | Begin a burst |
| start_col | input | COL_W | Starting column |
| start_is_wr | input | 1 | 1 = the burst is a write |
| stop | input | 1 | Burst-stop or precharge request |
| col_addr | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is present |
| col_last | output | 1 | Current beat is the final one |

## Verification
On every cycle, assertions check the following:
- the first beat after a start carries the starting column;
- a last beat with no restart is followed by silence;
- a stop always flags the current beat;
- a single-beat write ends at once;
- the beat counter steps by one;
- a full-page burst never ends without a stop;
- the latched mode holds still during a burst.

Only the bench's scenarios can show the actual address orderings: sequential wrap inside a block, the XOR order, the page wrap and the fallback from interleaved to sequential in full-page mode. The same holds for the burst length of each code and for mode changes or restarts in the middle of a burst. The bench compares these against a reference model over directed cases and random stimulus.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

    typedef enum logic [2:0] {
        BLEN_1    = 3'd0,
        BLEN_2    = 3'd1,
        BLEN_4    = 3'd2,
        BLEN_8    = 3'd3,
        BLEN_PAGE = 3'd7
    } blen_code_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    // Latched burst plan: page-wide or 2**shift beats
    typedef struct packed {
        logic       page;
        order_e     order;
        logic [1:0] shift;
    } burst_plan_t;

    function automatic burst_plan_t decode_plan(logic [2:0] code, logic ilv, logic one_beat);
        burst_plan_t p;
        p.page  = 1'b0;
        p.shift = 2'd0;
        if (!one_beat) begin
            case (code)
                BLEN_2:    p.shift = 2'd1;
                BLEN_4:    p.shift = 2'd2;
                BLEN_8:    p.shift = 2'd3;
                BLEN_PAGE: p.page  = 1'b1;
                default:   p.shift = 2'd0;
            endcase
        end
        // Interleaved order has no meaning across a page; fall back to sequential
        p.order = (ilv && !p.page) ? ORD_ILV : ORD_SEQ;
        return p;
    endfunction

endpackage

// File: rtl/sdram_colgen_mode.sv
module sdram_colgen_mode
    import sdram_colgen_pkg::*;
(
    input  logic [2:0]  mode_blen,
    input  logic        mode_ilv,
    input  logic        mode_wr_single,
    input  logic        start_is_wr,
    output burst_plan_t plan
);
    logic one_beat;

    always_comb begin
        one_beat = mode_wr_single && start_is_wr;
        plan     = decode_plan(mode_blen, mode_ilv, one_beat);
    end
endmodule

// File: rtl/sdram_colgen_beat.sv
module sdram_colgen_beat
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  burst_plan_t       plan_in,
    input  logic              stop,
    output logic              active_q,
    output burst_plan_t       plan_q,
    output logic [COL_W-1:0]  base_q,
    output logic [COL_W-1:0]  beat_q,
    output logic              end_beat
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic [COL_W-1:0] end_idx;

    always_comb begin
        end_idx  = (ONE << plan_q.shift) - ONE;
        end_beat = active_q && (stop || (!plan_q.page && beat_q == end_idx));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            plan_q   <= '0;
            base_q   <= '0;
            beat_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            plan_q   <= plan_in;
            base_q   <= start_col;
            beat_q   <= '0;
        end else if (end_beat) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            beat_q   <= beat_q + ONE;
        end
    end

    // R3: an unfinished burst advances by exactly one beat per clock
    assert_beat_step_R3: assert property (@(posedge clk) disable iff (rst)
        (active_q && !end_beat && !start) |=> (active_q && beat_q == $past(beat_q) + ONE));

    // R6: a page burst only ends on a stop
    assert_page_open_R6: assert property (@(posedge clk) disable iff (rst)
        (active_q && plan_q.page && !stop) |-> !end_beat);

    // R10: the latched plan holds until the next start
    assert_plan_held_R10: assert property (@(posedge clk) disable iff (rst)
        (active_q && !start) |=> $stable(plan_q));
endmodule

// File: rtl/sdram_colgen_addr.sv
module sdram_colgen_addr
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  burst_plan_t       plan,
    input  logic [COL_W-1:0]  base,
    input  logic [COL_W-1:0]  beat,
    output logic [COL_W-1:0]  addr
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic [COL_W-1:0] wrap_mask;
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] ilv_low;
    logic [COL_W-1:0] low_sel;

    always_comb begin
        wrap_mask = plan.page ? '1 : ((ONE << plan.shift) - ONE);
        seq_low   = base + beat;
        ilv_low   = base ^ beat;
        low_sel   = (plan.order == ORD_ILV) ? ilv_low : seq_low;
        addr      = (base & ~wrap_mask) | (low_sel & wrap_mask);
    end
endmodule

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_blen,
    input  logic              mode_ilv,
    input  logic              mode_wr_single,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              start_is_wr,
    input  logic              stop,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              col_last
);
    burst_plan_t      plan_new;
    burst_plan_t      plan_cur;
    logic             active;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] beat;
    logic             end_beat;

    sdram_colgen_mode u_mode (
        .mode_blen      (mode_blen),
        .mode_ilv       (mode_ilv),
        .mode_wr_single (mode_wr_single),
        .start_is_wr    (start_is_wr),
        .plan           (plan_new)
    );

    sdram_colgen_beat #(.COL_W(COL_W)) u_beat (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_col (start_col),
        .plan_in   (plan_new),
        .stop      (stop),
        .active_q  (active),
        .plan_q    (plan_cur),
        .base_q    (base),
        .beat_q    (beat),
        .end_beat  (end_beat)
    );

    sdram_colgen_addr #(.COL_W(COL_W)) u_addr (
        .plan (plan_cur),
        .base (base),
        .beat (beat),
        .addr (col_addr)
    );

    assign col_valid = active;
    assign col_last  = end_beat;

    // R2: first beat carries the starting column
    assert_first_beat_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (col_valid && col_addr == $past(start_col)));

    // R7: after a last beat with no restart the output falls silent
    assert_quiet_after_R7: assert property (@(posedge clk) disable iff (rst)
        (col_last && !start) |=> !col_valid);

    // R8: a stop on a live beat flags it last; last never appears without a beat
    assert_stop_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (stop && col_valid) |-> col_last);
    assert_last_has_beat_R8: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_valid);

    // R9: a single-beat write ends on its first beat
    assert_single_write_R9: assert property (@(posedge clk) disable iff (rst)
        (start && start_is_wr && mode_wr_single) |=> col_last);
endmodule

// File: tb/sdram_col_burst_gen_tb.sv
module sdram_col_burst_gen_tb;
    localparam int COL_W = 9;
    localparam int PAGE  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       mode_blen = 3'd0;
    logic             mode_ilv = 1'b0;
    logic             mode_wr_single = 1'b0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             start_is_wr = 1'b0;
    logic             stop = 1'b0;
    logic [COL_W-1:0] col_addr;
    logic             col_valid;
    logic             col_last;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;
    string phase_tag = "";

    // reference model state
    bit m_active = 1'b0;
    int m_base = 0;
    int m_cnt = 0;
    int m_n = 1;
    bit m_page = 1'b0;
    bit m_ilv = 1'b0;

    always #5 clk = ~clk;

    sdram_col_burst_gen #(.COL_W(COL_W)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .mode_blen      (mode_blen),
        .mode_ilv       (mode_ilv),
        .mode_wr_single (mode_wr_single),
        .start          (start),
        .start_col      (start_col),
        .start_is_wr    (start_is_wr),
        .stop           (stop),
        .col_addr       (col_addr),
        .col_valid      (col_valid),
        .col_last       (col_last)
    );

    function automatic int beats_of(int code, bit ws, bit wr);
        if (ws && wr) return 1;
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int model_addr();
        int off;
        int low;
        if (m_page) return (m_base + m_cnt) % PAGE;
        off = m_base % m_n;
        low = m_ilv ? (off ^ m_cnt) : ((off + m_cnt) % m_n);
        return (m_base - off) + low;
    endfunction

    function automatic bit model_last();
        return m_active && (stop || (!m_page && m_cnt == m_n - 1));
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_now();
        string vt;
        string at;
        string lt;
        vt = (phase_tag != "") ? phase_tag : "R3";
        at = (phase_tag != "") ? phase_tag : (m_page ? "R6" : (m_ilv ? "R5" : "R4"));
        lt = stop ? "R8" : "R7";
        cmp(vt, "col_valid", int'(col_valid), int'(m_active));
        cmp(lt, "col_last", int'(col_last), int'(model_last()));
        if (m_active) cmp(at, "col_addr", int'(col_addr), model_addr());
    endtask

    task automatic model_step();
        bit lst;
        lst = model_last();
        if (rst) begin
            m_active = 1'b0;
        end else if (start) begin
            int n;
            n        = beats_of(int'(mode_blen), mode_wr_single, start_is_wr);
            m_active = 1'b1;
            m_base   = int'(start_col);
            m_cnt    = 0;
            m_page   = (n == 0);
            m_n      = (n == 0) ? PAGE : n;
            m_ilv    = mode_ilv && (n != 0);
        end else if (lst) begin
            m_active = 1'b0;
        end else if (m_active) begin
            m_cnt = (m_cnt + 1) % PAGE;
        end
    endtask

    task automatic cyc(bit s, int col, bit wr, bit sp, int blen, bit ilv, bit ws);
        @(negedge clk);
        start          = s;
        start_col      = COL_W'(col);
        start_is_wr    = wr;
        stop           = sp;
        mode_blen      = 3'(blen);
        mode_ilv       = ilv;
        mode_wr_single = ws;
        #1;
        check_now();
        model_step();
    endtask

    task automatic idle(int n, int blen, bit ilv, bit ws);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 1'b0, 1'b0, blen, ilv, ws);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset holds the outputs idle
        phase_tag = "R1";
        for (int i = 0; i < 3; i++) cyc(1'b0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        rst = 1'b0;
        idle(2, 3, 1'b0, 1'b0);

        // R2, R4: sequential 8-beat burst wrapping inside its block
        phase_tag = "R2";
        cyc(1'b1, 9'h0D5, 1'b0, 1'b0, 3, 1'b0, 1'b0);
        phase_tag = "R4";
        idle(9, 3, 1'b0, 1'b0);

        // R5: interleaved 8, 4 and 2 beat bursts
        phase_tag = "R5";
        cyc(1'b1, 9'h0D5, 1'b0, 1'b0, 3, 1'b1, 1'b0);
        idle(9, 0, 1'b0, 1'b0);
        cyc(1'b1, 9'h1A6, 1'b0, 1'b0, 2, 1'b1, 1'b0);
        idle(5, 0, 1'b0, 1'b0);
        cyc(1'b1, 9'h033, 1'b0, 1'b0, 1, 1'b1, 1'b0);
        idle(3, 0, 1'b0, 1'b0);

        // R6: page burst across the top of the page, interleave ignored, then R8 stop
        phase_tag = "R6";
        cyc(1'b1, 9'h1FC, 1'b0, 1'b0, 7, 1'b1, 1'b0);
        idle(10, 7, 1'b1, 1'b0);
        phase_tag = "R8";
        cyc(1'b0, 0, 1'b0, 1'b1, 7, 1'b1, 1'b0);
        idle(2, 7, 1'b0, 1'b0);
        // R8: stop while idle is ignored
        cyc(1'b0, 0, 1'b0, 1'b1, 3, 1'b0, 1'b0);
        // R8: stop on the first beat of an 8-beat burst
        cyc(1'b1, 9'h040, 1'b0, 1'b0, 3, 1'b0, 1'b0);
        cyc(1'b0, 0, 1'b0, 1'b1, 3, 1'b0, 1'b0);
        idle(2, 3, 1'b0, 1'b0);

        // R9: single-beat write, read with the option on, write with it off
        phase_tag = "R9";
        cyc(1'b1, 9'h111, 1'b1, 1'b0, 3, 1'b0, 1'b1);
        idle(3, 3, 1'b0, 1'b1);
        cyc(1'b1, 9'h111, 1'b0, 1'b0, 3, 1'b0, 1'b1);
        idle(9, 3, 1'b0, 1'b1);
        cyc(1'b1, 9'h111, 1'b1, 1'b0, 2, 1'b0, 1'b0);
        idle(5, 2, 1'b0, 1'b0);

        // R3: reserved length code gives one beat
        phase_tag = "R3";
        cyc(1'b1, 9'h0F0, 1'b0, 1'b0, 5, 1'b0, 1'b0);
        idle(3, 0, 1'b0, 1'b0);

        // R10: mode changes mid-burst have no effect
        phase_tag = "R10";
        cyc(1'b1, 9'h07B, 1'b0, 1'b0, 3, 1'b0, 1'b0);
        idle(3, 7, 1'b1, 1'b1);
        idle(6, 1, 1'b1, 1'b0);

        // R11: restart in the middle of a burst
        phase_tag = "R11";
        cyc(1'b1, 9'h150, 1'b0, 1'b0, 3, 1'b0, 1'b0);
        idle(3, 3, 1'b0, 1'b0);
        cyc(1'b1, 9'h0A2, 1'b0, 1'b0, 2, 1'b1, 1'b0);
        idle(6, 2, 1'b1, 1'b0);

        // random mix, all requirements
        phase_tag = "";
        for (int i = 0; i < 4000; i++) begin
            bit s;
            bit sp;
            int code;
            int pick;
            s    = (($urandom % 6) == 0);
            sp   = (($urandom % 12) == 0);
            pick = $urandom % 8;
            code = (pick < 5) ? pick : ((pick == 5) ? 7 : 4 + ($urandom % 3));
            if (pick == 4) code = 7;
            cyc(s, int'($urandom % PAGE), 1'($urandom), sp, code, 1'($urandom), 1'($urandom));
        end

        finish_run();
    end
endmodule